// File: doc/BRIEF.md
# Dual-Condition Key Interrupt Generator

This block produces the active-low interrupt request of a key-scan controller. Two conditions can raise it. The first is time-based: after a key event, it counts debounce-cycle ticks. The second watches FIFO occupancy: the stored event count crosses a programmed threshold. Both conditions are programmed through one 8-bit interrupt setting. The request latches on whichever condition is met first and stays asserted until the host performs the chosen clear action.

A single configuration bit selects the clear action. One choice is a read of the key FIFO. The other is a read of the interrupt setting itself. An all-zero interrupt setting turns the output off completely. Sleep and wake handling belong elsewhere.

Top module: `key_irq_gen`

## Requirements
- R1: While rst_ni is low and after its release, irq_no is high (no request) until a condition fires.
- R2: While irq_cfg_i equals 0x00, irq_no is high at the next clock edge, whatever the other inputs do, and any pending request is dropped.
- R3: The time field is irq_cfg_i[4:0] = N. When N is nonzero, irq_no goes low at the clock edge that samples the N-th dbc_tick_i pulse after the latest key_evt_i. Ticks with no pending key event do not fire. A fired timer stays quiet until the next key event.
- R4: A key_evt_i pulse restarts the debounce-tick count from zero, including while a count is in progress.
- R5: The depth field is irq_cfg_i[7:5] = n. When n is nonzero, the threshold is 2*n events. irq_no goes low at the clock edge where fifo_cnt_i first reaches or exceeds the threshold after having been below it. A count that stays at or above the threshold does not raise the request again.
- R6: A time field of 0 disables the time condition. A depth field of 0 disables the depth condition.
- R7: When both fields are nonzero, the request asserts at the edge of whichever condition is met first.
- R8: With clr_on_fifo_rd_i = 1, a fifo_rd_i pulse drops the request (irq_no high) at the next edge. irq_reg_rd_i has no effect in this mode.
- R9: With clr_on_fifo_rd_i = 0, an irq_reg_rd_i pulse drops the request at the next edge. fifo_rd_i has no effect in this mode.
- R10: Once low, irq_no stays low until the selected clear occurs or the setting becomes 0x00. A condition firing in the same cycle as a clear keeps the request asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_cfg_i | input | 8 | Interrupt setting: [7:5] depth field, [4:0] time field |
| clr_on_fifo_rd_i | input | 1 | 1: FIFO read clears the request; 0: interrupt-setting read clears it |
| dbc_tick_i | input | 1 | One-cycle pulse per completed debounce cycle |
| key_evt_i | input | 1 | One-cycle pulse per debounced key event |
| fifo_cnt_i | input | CNT_W (5) | Number of events held in the key FIFO |
| fifo_rd_i | input | 1 | One-cycle pulse on a host read of the key FIFO |
| irq_reg_rd_i | input | 1 | One-cycle pulse on a host read of the interrupt setting |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Every result is due exactly one clock edge after the input that causes it. The output is taken straight from the request flop, and the tick counter and depth edge detector feed that flop in the same cycle. The bench drives inputs just after a falling edge and holds each pulse for one cycle. It samples irq_no at the next falling edge, half a period after the capturing rising edge. For the time condition, the bench samples after each tick, so the check also confirms the request did not assert one tick early. For the depth condition, it samples after the count step just below the threshold and again at the threshold.

// File: rtl/key_irq_pkg.sv
package key_irq_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned TSEL_W   = 5;
  localparam int unsigned DSEL_W   = CFG_W - TSEL_W;

  typedef struct packed {
    logic [DSEL_W-1:0] dsel;
    logic [TSEL_W-1:0] tsel;
  } irq_cfg_t;

  // threshold is twice the field value
  function automatic logic [DSEL_W:0] depth_thr(input logic [DSEL_W-1:0] sel);
    return {sel, 1'b0};
  endfunction
endpackage

// File: rtl/key_irq_timer.sv
module key_irq_timer #(
  parameter int unsigned TSEL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic              key_evt_i,
  input  logic              tick_i,
  output logic              fire_o
);
  logic              armed_q;
  logic [TSEL_W-1:0] cnt_q;
  logic              en;
  logic              last;

  assign en     = (tsel_i != '0);
  assign last   = (cnt_q == tsel_i - TSEL_W'(1));
  assign fire_o = en && armed_q && tick_i && !key_evt_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (key_evt_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (en && armed_q && tick_i) begin
      if (last) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + TSEL_W'(1);
      end
    end
  end
endmodule

// File: rtl/key_irq_depth.sv
module key_irq_depth
  import key_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DSEL_W-1:0] dsel_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  output logic              fire_o
);
  localparam int unsigned THR_W = DSEL_W + 1;
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] thr;
  logic [CMP_W-1:0] cnt;
  logic             hit;
  logic             hit_q;

  assign thr    = CMP_W'(depth_thr(dsel_i));
  assign cnt    = CMP_W'(fifo_cnt_i);
  assign hit    = (dsel_i != '0) && (cnt >= thr);
  assign fire_o = hit && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end
endmodule

// File: rtl/key_irq_latch.sv
module key_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_i,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_o <= 1'b0;
    else if (off_i) req_o <= 1'b0;
    else if (set_i) req_o <= 1'b1;  // set beats clear
    else if (clr_i) req_o <= 1'b0;
  end
endmodule

// File: rtl/key_irq_gen.sv
module key_irq_gen
  import key_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       irq_cfg_i,
  input  logic             clr_on_fifo_rd_i,
  input  logic             dbc_tick_i,
  input  logic             key_evt_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             fifo_rd_i,
  input  logic             irq_reg_rd_i,
  output logic             irq_no
);
  irq_cfg_t cfg;
  logic     time_fire;
  logic     depth_fire;
  logic     irq_set;
  logic     irq_clr;
  logic     irq_off;
  logic     req;

  assign cfg     = irq_cfg_t'(irq_cfg_i);
  assign irq_off = (irq_cfg_i == '0);
  assign irq_set = time_fire | depth_fire;
  assign irq_clr = clr_on_fifo_rd_i ? fifo_rd_i : irq_reg_rd_i;

  key_irq_timer #(.TSEL_W(TSEL_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tsel_i    (cfg.tsel),
    .key_evt_i (key_evt_i),
    .tick_i    (dbc_tick_i),
    .fire_o    (time_fire)
  );

  key_irq_depth #(.CNT_W(CNT_W)) u_depth (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dsel_i     (cfg.dsel),
    .fifo_cnt_i (fifo_cnt_i),
    .fire_o     (depth_fire)
  );

  key_irq_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .off_i  (irq_off),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .req_o  (req)
  );

  assign irq_no = ~req;
endmodule

// File: rtl/key_irq_gen_chk.sv
module key_irq_gen_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       irq_cfg_i,
  input logic             clr_on_fifo_rd_i,
  input logic             fifo_rd_i,
  input logic             irq_reg_rd_i,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             time_fire,
  input logic             irq_set,
  input logic             irq_no
);
  logic       m_hit;
  logic       m_hit_q;
  logic       sel_clr;
  logic [5:0] m_thr;

  assign m_thr   = 6'(irq_cfg_i[7:5]) * 6'd2;
  assign m_hit   = (irq_cfg_i[7:5] != 3'd0) && (6'(fifo_cnt_i) >= m_thr);
  assign sel_clr = clr_on_fifo_rd_i ? fifo_rd_i : irq_reg_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_hit_q <= 1'b0;
    else         m_hit_q <= m_hit;
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) !rst_ni |-> irq_no);

  assert_cfg_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cfg_i == 8'h00) |=> irq_no);

  assert_time_fire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_fire |=> !irq_no);

  assert_depth_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_hit && !m_hit_q && irq_cfg_i != 8'h00) |=> !irq_no);

  // R8 and R9: selected clear with no new condition drops the request
  assert_sel_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_clr && !irq_set) |=> irq_no);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !sel_clr && irq_cfg_i != 8'h00) |=> !irq_no);
endmodule

bind key_irq_gen key_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .irq_cfg_i        (irq_cfg_i),
  .clr_on_fifo_rd_i (clr_on_fifo_rd_i),
  .fifo_rd_i        (fifo_rd_i),
  .irq_reg_rd_i     (irq_reg_rd_i),
  .fifo_cnt_i       (fifo_cnt_i),
  .time_fire        (time_fire),
  .irq_set          (irq_set),
  .irq_no           (irq_no)
);

// File: tb/key_irq_gen_tb.sv
module key_irq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       irq_cfg_i = 8'h00;
  logic             clr_on_fifo_rd_i = 1'b0;
  logic             dbc_tick_i = 1'b0;
  logic             key_evt_i = 1'b0;
  logic [CNT_W-1:0] fifo_cnt_i = '0;
  logic             fifo_rd_i = 1'b0;
  logic             irq_reg_rd_i = 1'b0;
  logic             irq_no;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  key_irq_gen #(.CNT_W(CNT_W)) u_dut (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .irq_cfg_i        (irq_cfg_i),
    .clr_on_fifo_rd_i (clr_on_fifo_rd_i),
    .dbc_tick_i       (dbc_tick_i),
    .key_evt_i        (key_evt_i),
    .fifo_cnt_i       (fifo_cnt_i),
    .fifo_rd_i        (fifo_rd_i),
    .irq_reg_rd_i     (irq_reg_rd_i),
    .irq_no           (irq_no)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (irq_no !== exp) begin
      fails++;
      $display("FAIL %s irq_no actual=%b expected=%b t=%0t", req, irq_no, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic key_pulse();
    key_evt_i = 1'b1; @(negedge clk_i); key_evt_i = 1'b0;
  endtask

  task automatic tick_pulse();
    dbc_tick_i = 1'b1; @(negedge clk_i); dbc_tick_i = 1'b0;
  endtask

  task automatic set_cnt(input int v);
    fifo_cnt_i = CNT_W'(v); @(negedge clk_i);
  endtask

  task automatic fifo_read();
    fifo_rd_i = 1'b1; @(negedge clk_i); fifo_rd_i = 1'b0;
  endtask

  task automatic reg_read();
    irq_reg_rd_i = 1'b1; @(negedge clk_i); irq_reg_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 during reset", 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);
    chk("R1 after release", 1'b1);
  endtask

  task automatic t_time();
    irq_cfg_i = 8'h03; clr_on_fifo_rd_i = 1'b0; idle(1);
    tick_pulse(); tick_pulse(); tick_pulse();
    chk("R3 ticks with no key event", 1'b1);
    key_pulse();
    tick_pulse(); tick_pulse();
    chk("R3 two of three ticks", 1'b1);
    tick_pulse();
    chk("R3 third tick asserts", 1'b0);
    tick_pulse(); idle(3);
    chk("R10 held without clear", 1'b0);
    fifo_read();
    chk("R9 fifo read ignored in reg-clear mode", 1'b0);
    reg_read();
    chk("R9 reg read clears", 1'b1);
    tick_pulse(); tick_pulse(); tick_pulse(); tick_pulse();
    chk("R3 no refire without new key event", 1'b1);
  endtask

  task automatic t_restart();
    irq_cfg_i = 8'h03; clr_on_fifo_rd_i = 1'b0; idle(1);
    key_pulse(); tick_pulse(); tick_pulse();
    key_pulse(); tick_pulse(); tick_pulse();
    chk("R4 count restarted by key event", 1'b1);
    tick_pulse();
    chk("R4 fires after restart count", 1'b0);
    reg_read();
    chk("R9 clear after restart", 1'b1);
  endtask

  task automatic t_depth();
    set_cnt(0);
    irq_cfg_i = 8'h40; clr_on_fifo_rd_i = 1'b1; idle(1);
    set_cnt(3);
    chk("R5 below threshold 4", 1'b1);
    set_cnt(4);
    chk("R5 reaches threshold 4", 1'b0);
    reg_read();
    chk("R8 reg read ignored in fifo-clear mode", 1'b0);
    fifo_read();
    chk("R8 fifo read clears", 1'b1);
    idle(2);
    chk("R5 no reassert while above threshold", 1'b1);
    set_cnt(3); set_cnt(5);
    chk("R5 recross threshold", 1'b0);
    fifo_read(); set_cnt(0);
    irq_cfg_i = 8'hE0; idle(1);
    set_cnt(13);
    chk("R5 below threshold 14", 1'b1);
    set_cnt(14);
    chk("R5 reaches threshold 14", 1'b0);
    fifo_read(); set_cnt(0);
    chk("R8 clear before next test", 1'b1);
  endtask

  task automatic t_fields_off();
    set_cnt(0);
    irq_cfg_i = 8'h40; clr_on_fifo_rd_i = 1'b1; idle(1);
    key_pulse();
    for (int i = 0; i < 40; i++) tick_pulse();
    chk("R6 time field 0 disables timer", 1'b1);
    irq_cfg_i = 8'h05; idle(1);
    set_cnt(16);
    chk("R6 depth field 0 disables threshold", 1'b1);
    set_cnt(0);
  endtask

  task automatic t_zero();
    irq_cfg_i = 8'h00; clr_on_fifo_rd_i = 1'b0; idle(1);
    key_pulse(); set_cnt(16);
    for (int i = 0; i < 35; i++) tick_pulse();
    chk("R2 zero setting keeps output high", 1'b1);
    set_cnt(0);
    irq_cfg_i = 8'h01; idle(1);
    key_pulse(); tick_pulse();
    chk("R3 one-tick setting asserts", 1'b0);
    irq_cfg_i = 8'h00; idle(1);
    chk("R2 zero setting drops pending request", 1'b1);
  endtask

  task automatic t_both();
    set_cnt(0);
    irq_cfg_i = 8'h22; clr_on_fifo_rd_i = 1'b0; idle(1);
    key_pulse(); tick_pulse();
    chk("R7 neither met yet", 1'b1);
    set_cnt(2);
    chk("R7 depth first", 1'b0);
    reg_read(); set_cnt(0);
    chk("R9 cleared between", 1'b1);
    set_cnt(1);
    key_pulse(); tick_pulse();
    chk("R7 one tick, count 1", 1'b1);
    tick_pulse();
    chk("R7 time first", 1'b0);
    reg_read(); set_cnt(0);
  endtask

  task automatic t_set_wins();
    set_cnt(0);
    irq_cfg_i = 8'h40; clr_on_fifo_rd_i = 1'b1; idle(1);
    set_cnt(3);
    fifo_cnt_i = CNT_W'(4); fifo_rd_i = 1'b1; @(negedge clk_i); fifo_rd_i = 1'b0;
    chk("R10 set beats simultaneous clear", 1'b0);
    fifo_read();
    chk("R8 clear after set-wins", 1'b1);
    set_cnt(0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_time();
    t_restart();
    t_depth();
    t_fields_off();
    t_zero();
    t_both();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule